// File: doc/BRIEF.md
# UART Status Flags and Interrupt Combiner

This block keeps the eight status flags of a UART and sits between the serial core and the CPU register bus. The core reports events as single-cycle pulses: the transmit buffer was taken by the shifter, a frame finished, a word arrived (with its noise, framing and parity qualifiers), or the line went idle. The block also watches bus reads and writes to the status and data registers. It holds the received word for the CPU, holds the byte the CPU wrote for the transmitter, and drives one registered interrupt line built from per-source enables.

Flags never clear on their own. Software first reads the status register, which records which flags were set at that moment. A later data-register access then clears only those recorded flags. A write clears the transmit group, and a read clears the receive group. A flag that sets between the two accesses stays set. The receive path handles overrun by keeping the held word. The idle flag can only fire again after a fresh word has been received.

Top module: `uart_flag_ctrl`

## Requirements
- R1: Out of reset `stat_q` is 0xC0 and `irq` is 0. The bit positions from bit 7 down to bit 0 are: tx-empty, tx-done, rx-ready, idle, overrun, noise, framing, parity.
- R2: `ev_tx_load` sets tx-empty (bit 7) only when bit 7 is 0. While bit 7 is 1 the pulse is ignored and `stat_q` is unchanged.
- R3: `ev_tx_done` sets tx-done (bit 6) unless `ev_tx_special` is high in the same cycle. With `ev_tx_special` high, bit 6 is not set.
- R4: A status read records the flags as they stand at that edge. A later data write clears the recorded bits 7 and 6. A later data read clears the recorded bits 5 to 0. Each data access uses up the record for its own group. Flags not recorded stay set.
- R5: A data read or write with no recorded status read clears no flag.
- R6: `ev_rx_word` while bit 5 is 0 (or is being cleared in that cycle) copies `rx_shift_data` to `rx_data_q` and sets bit 5. It also sets bits 2, 1 and 0 from `rx_noise`, `rx_frame_err` and `rx_parity_err`.
- R7: `ev_rx_word` while bit 5 stays 1 sets overrun (bit 3). It leaves `rx_data_q` and bits 2, 1 and 0 unchanged, so a framing error is not flagged.
- R8: `ev_rx_idle` sets bit 4 only while the idle re-arm is active. The re-arm is active after reset, drops when bit 4 is cleared, and returns on the next R6 transfer.
- R9: `irq` is registered and, one cycle later, equals the OR of bit7&`en_tx_empty`, bit6&`en_tx_done`, (bit5|bit3)&`en_rx`, bit4&`en_idle` and bit0&`en_parity`. Bits 2 and 1 raise no interrupt.
- R10: When a set event and a clearing access hit the same flag in one cycle, the flag ends up set.
- R11: Every data write loads `bus_wdata` into `tx_data_q`, whether or not a clear was recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_load | input | 1 | Shifter took the transmit buffer |
| ev_tx_done | input | 1 | Transmit frame finished |
| ev_tx_special | input | 1 | Finished frame was a preamble or break |
| ev_rx_word | input | 1 | Received word ready in shifter |
| rx_shift_data | input | DW | Received word |
| rx_noise | input | 1 | Noise seen on this word |
| rx_frame_err | input | 1 | Framing error on this word |
| rx_parity_err | input | 1 | Parity error on this word |
| ev_rx_idle | input | 1 | Idle line detected |
| bus_sel_stat | input | 1 | Bus selects status register |
| bus_sel_data | input | 1 | Bus selects data register |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | DW | Bus write data |
| en_tx_empty | input | 1 | Interrupt enable for tx-empty |
| en_tx_done | input | 1 | Interrupt enable for tx-done |
| en_rx | input | 1 | Interrupt enable for rx-ready or overrun |
| en_idle | input | 1 | Interrupt enable for idle |
| en_parity | input | 1 | Interrupt enable for parity |
| stat_q | output | 8 | Status flags |
| rx_data_q | output | DW | Held received word |
| tx_data_q | output | DW | Byte for the transmitter |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets these corner cases:
- A data access with no status read before it. A design that cleared on any data access would drop flags here.
- An overrun that carries a framing error. A wrong design would set the framing bit or overwrite the held word.
- A flag that sets between the status read and the data read. A design that cleared the whole group would lose it.
- Idle events after idle has been cleared, before and after a new word arrives. A missing re-arm gate would set idle twice for one idle period.
- A data read that lands in the same cycle as a new word. This checks that the word is transferred and not flagged as an overrun.
- A preamble or break completion. This checks that tx-done stays clear.

// File: rtl/uflag_pkg.sv
package uflag_pkg;
  localparam int NFLAG = 8;
  localparam int B_TXE = 7;
  localparam int B_TXC = 6;
  localparam int B_RXR = 5;
  localparam int B_IDL = 4;
  localparam int B_OVR = 3;
  localparam int B_NSE = 2;
  localparam int B_FRM = 1;
  localparam int B_PAR = 0;
  localparam logic [NFLAG-1:0] TX_GRP = 8'hC0;
  localparam logic [NFLAG-1:0] RX_GRP = 8'h3F;
  localparam logic [NFLAG-1:0] STAT_RST = 8'hC0;
  localparam int NIRQ = 5;
endpackage

// File: rtl/uflag_clear_seq.sv
module uflag_clear_seq
  import uflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             stat_rd,
  input  logic             data_rd,
  input  logic             data_wr,
  input  logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] clr
);
  logic [NFLAG-1:0] arm_q;
  logic [NFLAG-1:0] arm_d;

  always_comb begin
    clr = '0;
    if (data_rd) clr = clr | (arm_q & RX_GRP);
    if (data_wr) clr = clr | (arm_q & TX_GRP);
  end

  always_comb begin
    arm_d = arm_q;
    if (stat_rd) begin
      arm_d = flags;
    end else begin
      if (data_rd) arm_d = arm_d & ~RX_GRP;
      if (data_wr) arm_d = arm_d & ~TX_GRP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) arm_q <= '0;
    else     arm_q <= arm_d;
  end
endmodule

// File: rtl/uflag_tx.sv
module uflag_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_load,
  input  logic          ev_done,
  input  logic          ev_special,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          clr_txe,
  input  logic          clr_txc,
  output logic          txe,
  output logic          txc,
  output logic [DW-1:0] txbuf
);
  logic txe_d, txc_d;

  always_comb begin
    txe_d = txe & ~clr_txe;
    if (ev_load && !txe) txe_d = 1'b1;
    txc_d = txc & ~clr_txc;
    if (ev_done && !ev_special) txc_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txe   <= 1'b1;
      txc   <= 1'b1;
      txbuf <= '0;
    end else begin
      txe <= txe_d;
      txc <= txc_d;
      if (wr) txbuf <= wdata;
    end
  end
endmodule

// File: rtl/uflag_rx.sv
module uflag_rx
  import uflag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_word,
  input  logic [DW-1:0] shift_data,
  input  logic          noise,
  input  logic          ferr,
  input  logic          perr,
  input  logic          ev_idle,
  input  logic [5:0]    clr,
  output logic [5:0]    flags,
  output logic [DW-1:0] rx_data
);
  logic [5:0] fl_d;
  logic       xfer, ovr, idle_arm_q, idle_arm_d;

  always_comb begin
    fl_d = flags & ~clr;
    xfer = ev_word & ~fl_d[B_RXR];
    ovr  = ev_word &  fl_d[B_RXR];
    if (xfer) begin
      fl_d[B_RXR] = 1'b1;
      fl_d[B_NSE] = fl_d[B_NSE] | noise;
      fl_d[B_FRM] = fl_d[B_FRM] | ferr;
      fl_d[B_PAR] = fl_d[B_PAR] | perr;
    end
    if (ovr) fl_d[B_OVR] = 1'b1;
    if (ev_idle && idle_arm_q) fl_d[B_IDL] = 1'b1;
    if (xfer)             idle_arm_d = 1'b1;
    else if (clr[B_IDL])  idle_arm_d = 1'b0;
    else                  idle_arm_d = idle_arm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags      <= '0;
      rx_data    <= '0;
      idle_arm_q <= 1'b1;
    end else begin
      flags      <= fl_d;
      idle_arm_q <= idle_arm_d;
      if (xfer) rx_data <= shift_data;
    end
  end
endmodule

// File: rtl/uflag_irq.sv
module uflag_irq #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] en,
  output logic            irq
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = src[g] & en[g];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |hit;
  end
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uflag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_tx_load,
  input  logic          ev_tx_done,
  input  logic          ev_tx_special,
  input  logic          ev_rx_word,
  input  logic [DW-1:0] rx_shift_data,
  input  logic          rx_noise,
  input  logic          rx_frame_err,
  input  logic          rx_parity_err,
  input  logic          ev_rx_idle,
  input  logic          bus_sel_stat,
  input  logic          bus_sel_data,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          en_tx_empty,
  input  logic          en_tx_done,
  input  logic          en_rx,
  input  logic          en_idle,
  input  logic          en_parity,
  output logic [7:0]    stat_q,
  output logic [DW-1:0] rx_data_q,
  output logic [DW-1:0] tx_data_q,
  output logic          irq
);
  logic             stat_rd, data_rd, data_wr;
  logic [NFLAG-1:0] clr;
  logic             txe, txc;
  logic [5:0]       rxf;
  logic [NIRQ-1:0]  isrc, ien;

  assign stat_rd = bus_sel_stat & bus_rd;
  assign data_rd = bus_sel_data & bus_rd;
  assign data_wr = bus_sel_data & bus_wr;
  assign stat_q  = {txe, txc, rxf};

  uflag_clear_seq u_seq (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_wr(data_wr), .flags(stat_q), .clr(clr)
  );

  uflag_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .ev_load(ev_tx_load), .ev_done(ev_tx_done),
    .ev_special(ev_tx_special), .wr(data_wr), .wdata(bus_wdata),
    .clr_txe(clr[B_TXE]), .clr_txc(clr[B_TXC]),
    .txe(txe), .txc(txc), .txbuf(tx_data_q)
  );

  uflag_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .ev_word(ev_rx_word), .shift_data(rx_shift_data),
    .noise(rx_noise), .ferr(rx_frame_err), .perr(rx_parity_err),
    .ev_idle(ev_rx_idle), .clr(clr[5:0]), .flags(rxf), .rx_data(rx_data_q)
  );

  assign isrc = {txe, txc, rxf[B_RXR] | rxf[B_OVR], rxf[B_IDL], rxf[B_PAR]};
  assign ien  = {en_tx_empty, en_tx_done, en_rx, en_idle, en_parity};

  uflag_irq #(.NSRC(NIRQ)) u_irq (
    .clk(clk), .rst(rst), .src(isrc), .en(ien), .irq(irq)
  );
endmodule

// File: rtl/uflag_chk.sv
module uflag_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ev_tx_done,
  input logic          ev_tx_special,
  input logic          ev_rx_word,
  input logic          bus_sel_data,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          en_rx,
  input logic [7:0]    stat_q,
  input logic [DW-1:0] rx_data_q,
  input logic          irq
);
  assert_special_no_tc_R3: assert property (@(posedge clk) disable iff (rst)
    (!stat_q[6] && ev_tx_done && ev_tx_special) |=> !stat_q[6]);

  assert_txe_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_q[7] && !(bus_sel_data && bus_wr)) |=> stat_q[7]);

  assert_rxr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_q[5] && !(bus_sel_data && bus_rd)) |=> stat_q[5]);

  assert_ovr_keeps_data_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_q[5] && ev_rx_word && !(bus_sel_data && bus_rd)) |=> (stat_q[3] && $stable(rx_data_q)));

  assert_ovr_no_fe_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_q[5] && !stat_q[1] && ev_rx_word && !(bus_sel_data && bus_rd)) |=> !stat_q[1]);

  assert_irq_rx_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_q[5] && en_rx) |=> irq);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_q[7:3] == 5'b0 && !stat_q[0]) |=> !irq);
endmodule

bind uart_flag_ctrl uflag_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ev_tx_done(ev_tx_done), .ev_tx_special(ev_tx_special),
  .ev_rx_word(ev_rx_word), .bus_sel_data(bus_sel_data), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .en_rx(en_rx), .stat_q(stat_q), .rx_data_q(rx_data_q),
  .irq(irq)
);

// File: tb/sim_uart_flag_ctrl.sv
`timescale 1ns/1ps
module sim_uart_flag_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_tx_load = 0, ev_tx_done = 0, ev_tx_special = 0, ev_rx_word = 0;
  logic [7:0] rx_shift_data = 0;
  logic rx_noise = 0, rx_frame_err = 0, rx_parity_err = 0, ev_rx_idle = 0;
  logic bus_sel_stat = 0, bus_sel_data = 0, bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic en_tx_empty = 0, en_tx_done = 0, en_rx = 0, en_idle = 0, en_parity = 0;
  logic [7:0] stat_q, rx_data_q, tx_data_q;
  logic irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_flag_ctrl #(.DW(8)) u0 (.*);

  // behavioural reference model, updated on every rising edge
  bit [7:0] m_stat, m_arm, m_rx, m_tx;
  bit       m_iarm, m_irq;

  always @(posedge clk) begin
    bit [7:0] s, clr, a;
    bit got;
    if (rst) begin
      m_stat <= 8'hC0; m_arm <= 0; m_rx <= 0; m_tx <= 0; m_iarm <= 1; m_irq <= 0;
    end else begin
      clr = 0;
      if (bus_sel_data && bus_rd) clr = clr | (m_arm & 8'h3F);
      if (bus_sel_data && bus_wr) clr = clr | (m_arm & 8'hC0);
      s = m_stat & ~clr;
      if (ev_tx_load && !m_stat[7]) s[7] = 1;
      if (ev_tx_done && !ev_tx_special) s[6] = 1;
      got = 0;
      if (ev_rx_word) begin
        if (!s[5]) begin
          got = 1; s[5] = 1;
          if (rx_noise) s[2] = 1;
          if (rx_frame_err) s[1] = 1;
          if (rx_parity_err) s[0] = 1;
          m_rx <= rx_shift_data;
        end else s[3] = 1;
      end
      if (ev_rx_idle && m_iarm) s[4] = 1;
      if (got) m_iarm <= 1;
      else if (clr[4]) m_iarm <= 0;
      a = m_arm;
      if (bus_sel_stat && bus_rd) a = m_stat;
      else begin
        if (bus_sel_data && bus_rd) a = a & 8'hC0;
        if (bus_sel_data && bus_wr) a = a & 8'h3F;
      end
      m_arm <= a;
      if (bus_sel_data && bus_wr) m_tx <= bus_wdata;
      m_irq <= (m_stat[7] & en_tx_empty) | (m_stat[6] & en_tx_done) |
               ((m_stat[5] | m_stat[3]) & en_rx) | (m_stat[4] & en_idle) |
               (m_stat[0] & en_parity);
      m_stat <= s;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R4 stat vs model", stat_q, m_stat);
    chk("R6 rx data vs model", rx_data_q, m_rx);
    chk("R11 tx data vs model", tx_data_q, m_tx);
    chk("R9 irq vs model", irq, m_irq);
  endtask

  task automatic quiet();
    ev_tx_load = 0; ev_tx_done = 0; ev_tx_special = 0; ev_rx_word = 0;
    rx_noise = 0; rx_frame_err = 0; rx_parity_err = 0; ev_rx_idle = 0;
    bus_sel_stat = 0; bus_sel_data = 0; bus_rd = 0; bus_wr = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (!rst) cmp_model();
    quiet();
  endtask

  task automatic stat_read();
    bus_sel_stat = 1; bus_rd = 1; tick();
  endtask

  task automatic data_read();
    bus_sel_data = 1; bus_rd = 1; tick();
  endtask

  task automatic data_write(input logic [7:0] d);
    bus_sel_data = 1; bus_wr = 1; bus_wdata = d; tick();
  endtask

  task automatic rx_word(input logic [7:0] d, input bit n, input bit f, input bit p);
    ev_rx_word = 1; rx_shift_data = d; rx_noise = n; rx_frame_err = f; rx_parity_err = p;
    tick();
  endtask

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset stat", stat_q, 8'hC0);
    chk("R1 reset irq", irq, 0);

    data_write(8'h5A);
    chk("R5 write without status read keeps flags", stat_q, 8'hC0);
    chk("R11 tx buffer loaded", tx_data_q, 8'h5A);

    stat_read();
    data_write(8'h33);
    chk("R4 write clears tx group", stat_q, 8'h00);

    ev_tx_load = 1; tick();
    chk("R2 load sets tx-empty", stat_q, 8'h80);
    ev_tx_done = 1; ev_tx_special = 1; tick();
    chk("R3 special frame leaves tx-done clear", stat_q, 8'h80);
    ev_tx_done = 1; tick();
    chk("R3 data frame sets tx-done", stat_q, 8'hC0);
    ev_tx_load = 1; tick();
    chk("R2 load ignored while tx-empty set", stat_q, 8'hC0);

    rx_word(8'hA1, 1, 0, 0);
    chk("R6 transfer sets rx-ready and noise", stat_q, 8'hE4);
    chk("R6 word held", rx_data_q, 8'hA1);
    rx_word(8'hB2, 0, 1, 0);
    chk("R7 overrun without framing bit", stat_q, 8'hEC);
    chk("R7 held word kept", rx_data_q, 8'hA1);

    data_read();
    chk("R5 read without status read keeps flags", stat_q, 8'hEC);

    ev_rx_idle = 1; tick();
    chk("R8 idle set when armed", stat_q, 8'hFC);
    stat_read();
    data_read();
    chk("R4 read clears rx group only", stat_q, 8'hC0);

    ev_rx_idle = 1; tick();
    chk("R8 idle not set before new word", stat_q, 8'hC0);
    rx_word(8'h11, 0, 0, 1);
    chk("R6 parity set on transfer", stat_q, 8'hE1);
    ev_rx_idle = 1; tick();
    chk("R8 idle re-armed by new word", stat_q, 8'hF1);

    stat_read();
    rx_word(8'h22, 0, 0, 0);
    data_read();
    chk("R4 overrun set after status read survives", stat_q, 8'hC8);
    chk("R7 data kept across overrun", rx_data_q, 8'h11);

    rx_word(8'h33, 0, 0, 0);
    chk("R6 transfer after clear", stat_q, 8'hE8);
    stat_read();
    ev_rx_word = 1; rx_shift_data = 8'h44; bus_sel_data = 1; bus_rd = 1; tick();
    chk("R10 set wins over clear", stat_q, 8'hE0);
    chk("R10 new word taken", rx_data_q, 8'h44);

    en_rx = 1; tick();
    chk("R9 irq from rx-ready", irq, 1);
    en_rx = 0; stat_read(); data_read();
    rx_word(8'h55, 0, 1, 0);
    en_parity = 1; tick(); tick();
    chk("R9 framing raises no irq", irq, 0);
    en_tx_empty = 1; tick();
    chk("R9 irq from tx-empty", irq, 1);
    en_tx_empty = 0; en_parity = 0;

    for (int i = 0; i < 3000; i++) begin
      ev_tx_load = ($urandom_range(0, 3) == 0);
      ev_tx_done = ($urandom_range(0, 4) == 0);
      ev_tx_special = ($urandom_range(0, 2) == 0);
      ev_rx_word = ($urandom_range(0, 3) == 0);
      rx_shift_data = 8'($urandom);
      rx_noise = ($urandom_range(0, 3) == 0);
      rx_frame_err = ($urandom_range(0, 3) == 0);
      rx_parity_err = ($urandom_range(0, 3) == 0);
      ev_rx_idle = ($urandom_range(0, 4) == 0);
      bus_sel_stat = ($urandom_range(0, 2) == 0);
      bus_sel_data = ($urandom_range(0, 2) == 0);
      bus_rd = $urandom_range(0, 1);
      bus_wr = $urandom_range(0, 1);
      bus_wdata = 8'($urandom);
      {en_tx_empty, en_tx_done, en_rx, en_idle, en_parity} = 5'($urandom);
      tick();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule